// File: doc/BRIEF.md
# Boost Output Clamp Supervisor

This block watches a digitized boost output voltage and decides when an active clamp should burn off surplus energy. The clamp switches on when the voltage code climbs above an upper fraction of a full-scale code and releases only once the voltage sinks under a lower fraction, giving a hysteresis band. Both fractions are fixed-point ratios applied to a full-scale code input, so the thresholds track whatever scale the converter front end reports.

Clamp activity is budgeted. A free-running window, counted in timebase ticks, collects the number of ticks during which the clamp was on. As soon as that count passes the budget, a sticky overpower fault is raised. The fault switches both power stages off and holds the clamp off until reset. A "recently clamped" indication stays up for a set number of half-line strobes after the clamp releases, for the regulation loops to use. A separate overvoltage flag is sampled against a higher fraction of full scale. A saturating up/down average of that flag, stepped on each tick, trips a sticky boost shutdown once it reaches an event level.

Top module: `clamp_supervisor`

## Requirements
- R1: While rst_n is low, and right after its release, clamp_en, cop_fault, clamp_recent, ov_flag and ov_shutdown are all 0.
- R2: With the clamp off and no fault, clamp_en goes to 1 at the first clock edge at which vcode is strictly greater than the turn-on threshold. A vcode equal to the threshold leaves it off.
- R3: With the clamp on and no fault, clamp_en stays 1 while vcode is greater than or equal to the turn-off threshold. It drops to 0 at the first edge at which vcode is strictly below that threshold.
- R4: The window spans WIN_TICKS ticks, numbered 0 to WIN_TICKS-1. On each tick except the last one, the on-time count grows by one if clamp_en is 1. On the last tick of the window, the count and the tick position both return to 0.
- R5: cop_fault becomes 1 one clock after the on-time count exceeds BUDGET_TICKS, at any point within the window. It then stays 1 until reset. A count equal to BUDGET_TICKS raises no fault.
- R6: While cop_fault is 1, clamp_en is 0. The clamp is forced off in the same cycle the fault appears.
- R7: clamp_recent is 1 whenever clamp_en is 1. After the clamp turns off, clamp_recent stays 1 until HOLD_HL half_line strobes have been seen with the clamp off. Clock cycles without a strobe do not shorten this hold.
- R8: ov_flag is a registered copy of whether vcode is strictly greater than the overvoltage threshold.
- R9: On each tick, an average counter rises by one when ov_flag is 1 and falls by one otherwise. It saturates at 0 and at 2^AVG_W-1. ov_shutdown is set one clock after the counter is at or above OV_EVENT, and it stays set until reset.
- R10: Each threshold equals floor(fs_code × K / 2^FRAC_W), using K_ON, K_OFF or K_OV respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcode | input | W | Digitized boost output voltage |
| fs_code | input | W | Full-scale reference code |
| tick | input | 1 | Timebase strobe for the window and the overvoltage average |
| half_line | input | 1 | Strobe once per rectified half-line cycle |
| clamp_en | output | 1 | Clamp transistor enable |
| cop_fault | output | 1 | Sticky clamp overpower fault, disables both stages |
| clamp_recent | output | 1 | Clamp on now or within the hold period |
| ov_flag | output | 1 | Voltage above the overvoltage threshold |
| ov_shutdown | output | 1 | Sticky boost shutdown from the averaged overvoltage flag |

## Verification
The assertions assume that fs_code changes only rarely compared with vcode, since they rebuild a threshold from the previous cycle's fs_code. They also assume that the ratios are ordered, with the turn-off ratio below the turn-on ratio, which is below the overvoltage ratio. The stimulus holds fs_code constant between resets and draws vcode mostly from values placed exactly on, just above and just below each threshold. Each value is held for several cycles so that the hysteresis band, the window wrap and the saturation limits are all reached under random tick and half-line strobes.

// File: rtl/clamp_sup_pkg.sv
`timescale 1ns/1ps
package clamp_sup_pkg;
   // floor(fs * k / 2^frac)
   function automatic logic [31:0] frac_scale(input logic [31:0] fs, input int unsigned k,
                                              input int unsigned frac);
      logic [63:0] prod;
      prod = {32'd0, fs} * {32'd0, k};
      prod = prod >> frac;
      return prod[31:0];
   endfunction

   localparam int unsigned NUM_TH = 3;
   typedef enum logic [1:0] {TH_ON = 2'd0, TH_OFF = 2'd1, TH_OV = 2'd2} th_sel_e;
endpackage

// File: rtl/clamp_sup_thresh.sv
`timescale 1ns/1ps
module clamp_sup_thresh #(
   parameter int unsigned W      = 10,
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned K_ON   = 3596,
   parameter int unsigned K_OFF  = 3486,
   parameter int unsigned K_OV   = 3840
) (
   input  logic [W-1:0] fs_code,
   output logic [W-1:0] th_on,
   output logic [W-1:0] th_off,
   output logic [W-1:0] th_ov
);
   import clamp_sup_pkg::*;

   localparam int unsigned KS [NUM_TH] = '{K_ON, K_OFF, K_OV};

   logic [W-1:0] th [NUM_TH];

   generate
      if (K_OFF >= K_ON) begin : g_bad_hyst
         $error("clamp_sup_thresh: K_OFF must be below K_ON");
      end
      if (K_OV >= (1 << FRAC_W)) begin : g_bad_ov
         $error("clamp_sup_thresh: ratios must be below one");
      end
      for (genvar g = 0; g < NUM_TH; g++) begin : g_th
         logic [31:0] scaled;
         assign scaled = frac_scale(32'(fs_code), KS[g], FRAC_W);
         assign th[g]  = scaled[W-1:0];
      end
   endgenerate

   assign th_on  = th[TH_ON];
   assign th_off = th[TH_OFF];
   assign th_ov  = th[TH_OV];
endmodule

// File: rtl/clamp_sup_window.sv
`timescale 1ns/1ps
module clamp_sup_window #(
   parameter int unsigned WIN_TICKS    = 2000,
   parameter int unsigned BUDGET_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clamp_on,
   output logic trip_now,
   output logic cop_fault
);
   localparam int unsigned PW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
   localparam int unsigned AW = $clog2(WIN_TICKS + 1);
   localparam logic [PW-1:0] LAST = PW'(WIN_TICKS - 1);
   localparam logic [AW-1:0] LIMIT = AW'(BUDGET_TICKS);

   generate
      if (BUDGET_TICKS >= WIN_TICKS - 1) begin : g_bad_budget
         $error("clamp_sup_window: budget must fit inside the window");
      end
   endgenerate

   logic [PW-1:0] pos_q;
   logic [AW-1:0] acc_q;

   assign trip_now = (acc_q > LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         acc_q <= '0;
      end else if (tick) begin
         if (pos_q == LAST) begin
            pos_q <= '0;
            acc_q <= '0;
         end else begin
            pos_q <= pos_q + 1'b1;
            acc_q <= acc_q + AW'(clamp_on);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cop_fault <= 1'b0;
      else if (trip_now) cop_fault <= 1'b1;
   end
endmodule

// File: rtl/clamp_sup_recent.sv
`timescale 1ns/1ps
module clamp_sup_recent #(
   parameter int unsigned HOLD_HL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_line,
   input  logic clamp_on,
   output logic recent
);
   generate
      if (HOLD_HL == 0) begin : g_direct
         assign recent = clamp_on;
      end else begin : g_hold
         localparam int unsigned RW = $clog2(HOLD_HL + 1);
         logic [RW-1:0] rem_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       rem_q <= '0;
            else if (clamp_on)                rem_q <= RW'(HOLD_HL);
            else if (half_line && rem_q != 0) rem_q <= rem_q - 1'b1;
         end
         assign recent = clamp_on | (rem_q != '0);
      end
   endgenerate
endmodule

// File: rtl/clamp_sup_ovavg.sv
`timescale 1ns/1ps
module clamp_sup_ovavg #(
   parameter int unsigned AVG_W    = 6,
   parameter int unsigned OV_EVENT = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic over,
   output logic shutdown
);
   localparam logic [AVG_W-1:0] TOP = {AVG_W{1'b1}};
   localparam logic [AVG_W-1:0] EVT = AVG_W'(OV_EVENT);

   generate
      if (OV_EVENT == 0 || OV_EVENT > (1 << AVG_W) - 1) begin : g_bad_evt
         $error("clamp_sup_ovavg: event level outside counter range");
      end
   endgenerate

   logic [AVG_W-1:0] avg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avg_q <= '0;
      end else if (tick) begin
         if (over && avg_q != TOP)           avg_q <= avg_q + 1'b1;
         else if (!over && avg_q != '0)      avg_q <= avg_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shutdown <= 1'b0;
      else if (avg_q >= EVT) shutdown <= 1'b1;
   end
endmodule

// File: rtl/clamp_supervisor.sv
`timescale 1ns/1ps
module clamp_supervisor #(
   parameter int unsigned W            = 10,
   parameter int unsigned FRAC_W       = 12,
   parameter int unsigned K_ON         = 3596,
   parameter int unsigned K_OFF        = 3486,
   parameter int unsigned K_OV         = 3840,
   parameter int unsigned WIN_TICKS    = 2000,
   parameter int unsigned BUDGET_TICKS = 200,
   parameter int unsigned HOLD_HL      = 4,
   parameter int unsigned AVG_W        = 6,
   parameter int unsigned OV_EVENT     = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] vcode,
   input  logic [W-1:0] fs_code,
   input  logic         tick,
   input  logic         half_line,
   output logic         clamp_en,
   output logic         cop_fault,
   output logic         clamp_recent,
   output logic         ov_flag,
   output logic         ov_shutdown
);
   generate
      if (K_OV <= K_ON) begin : g_bad_order
         $error("clamp_supervisor: overvoltage ratio must exceed turn-on ratio");
      end
   endgenerate

   logic [W-1:0] th_on, th_off, th_ov;
   logic         trip_now;
   logic         clamp_q;
   logic         clamp_d;
   logic         fault_d;

   clamp_sup_thresh #(.W(W), .FRAC_W(FRAC_W), .K_ON(K_ON), .K_OFF(K_OFF), .K_OV(K_OV)) u_thresh (
      .fs_code(fs_code), .th_on(th_on), .th_off(th_off), .th_ov(th_ov));

   clamp_sup_window #(.WIN_TICKS(WIN_TICKS), .BUDGET_TICKS(BUDGET_TICKS)) u_window (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clamp_on(clamp_q),
      .trip_now(trip_now), .cop_fault(cop_fault));

   clamp_sup_recent #(.HOLD_HL(HOLD_HL)) u_recent (
      .clk(clk), .rst_n(rst_n), .half_line(half_line), .clamp_on(clamp_q),
      .recent(clamp_recent));

   clamp_sup_ovavg #(.AVG_W(AVG_W), .OV_EVENT(OV_EVENT)) u_ovavg (
      .clk(clk), .rst_n(rst_n), .tick(tick), .over(ov_flag), .shutdown(ov_shutdown));

   // fault takes priority so the clamp drops on the same edge the fault rises
   assign fault_d = cop_fault | trip_now;

   always_comb begin
      clamp_d = clamp_q;
      if (fault_d)                        clamp_d = 1'b0;
      else if (!clamp_q && vcode > th_on) clamp_d = 1'b1;
      else if (clamp_q && vcode < th_off) clamp_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clamp_q <= 1'b0;
         ov_flag <= 1'b0;
      end else begin
         clamp_q <= clamp_d;
         ov_flag <= (vcode > th_ov);
      end
   end

   assign clamp_en = clamp_q;
endmodule

// File: rtl/clamp_supervisor_chk.sv
`timescale 1ns/1ps
module clamp_supervisor_chk #(
   parameter int unsigned W      = 10,
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned K_ON   = 3596,
   parameter int unsigned K_OFF  = 3486,
   parameter int unsigned K_OV   = 3840
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] vcode,
   input logic [W-1:0] fs_code,
   input logic         clamp_en,
   input logic         cop_fault,
   input logic         clamp_recent,
   input logic         ov_flag,
   input logic         ov_shutdown
);
   import clamp_sup_pkg::*;

   AST_RISE_ABOVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp_en) |-> (32'($past(vcode)) > frac_scale(32'($past(fs_code)), K_ON, FRAC_W))); // R2
   AST_FALL_BELOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(clamp_en) && !cop_fault) |-> (32'($past(vcode)) < frac_scale(32'($past(fs_code)), K_OFF, FRAC_W))); // R3
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cop_fault |=> cop_fault); // R5
   AST_FAULT_CLAMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cop_fault |-> !clamp_en); // R6
   AST_RECENT_COVERS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_en |-> clamp_recent); // R7
   AST_OV_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_flag) |-> (32'($past(vcode)) > frac_scale(32'($past(fs_code)), K_OV, FRAC_W))); // R8
   AST_SHUTDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ov_shutdown |=> ov_shutdown); // R9
endmodule

bind clamp_supervisor clamp_supervisor_chk #(.W(W), .FRAC_W(FRAC_W), .K_ON(K_ON), .K_OFF(K_OFF), .K_OV(K_OV)) u_chk (
   .clk(clk), .rst_n(rst_n), .vcode(vcode), .fs_code(fs_code), .clamp_en(clamp_en),
   .cop_fault(cop_fault), .clamp_recent(clamp_recent), .ov_flag(ov_flag), .ov_shutdown(ov_shutdown));

// File: tb/clamp_supervisor_tb.sv
`timescale 1ns/1ps
module clamp_supervisor_tb;
   localparam int W = 10, FR = 12, KON = 3596, KOFF = 3486, KOV = 3840;
   localparam int WIN = 40, BUD = 8, HOLD = 3, AVW = 4, EVT = 6;
   localparam int AVMAX = (1 << AVW) - 1;

   logic clk = 0, rst_n = 0, tick = 0, half_line = 0;
   logic [W-1:0] vcode = '0, fs_code = '0;
   logic clamp_en, cop_fault, clamp_recent, ov_flag, ov_shutdown;

   int checks = 0, failures = 0;
   int t_on, t_off, t_ov;
   bit m_clamp, m_fault, m_ovf, m_ovt;
   int m_win, m_acc, m_rc, m_ova;

   always #2 clk = ~clk;

   clamp_supervisor #(.W(W), .FRAC_W(FR), .K_ON(KON), .K_OFF(KOFF), .K_OV(KOV),
      .WIN_TICKS(WIN), .BUDGET_TICKS(BUD), .HOLD_HL(HOLD), .AVG_W(AVW), .OV_EVENT(EVT)) u_dut (
      .clk(clk), .rst_n(rst_n), .vcode(vcode), .fs_code(fs_code), .tick(tick),
      .half_line(half_line), .clamp_en(clamp_en), .cop_fault(cop_fault),
      .clamp_recent(clamp_recent), .ov_flag(ov_flag), .ov_shutdown(ov_shutdown));

   function automatic int scale(int fs, int k);
      return (fs * k) / (1 << FR); // R10
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      chk(clamp_en == m_clamp, "R2/R3/R6 clamp_en", int'(clamp_en), int'(m_clamp));
      chk(cop_fault == m_fault, "R4/R5 cop_fault", int'(cop_fault), int'(m_fault));
      chk(clamp_recent == (m_clamp || m_rc != 0), "R7 clamp_recent", int'(clamp_recent),
          int'(m_clamp || m_rc != 0));
      chk(ov_flag == m_ovf, "R8 ov_flag", int'(ov_flag), int'(m_ovf));
      chk(ov_shutdown == m_ovt, "R9 ov_shutdown", int'(ov_shutdown), int'(m_ovt));
   endtask

   task automatic cyc(input int v, input bit tk, input bit hl);
      bit nf, nc, no, nt;
      int nw, na, nr, nova;
      @(negedge clk);
      cmp_model();
      vcode = W'(v); tick = tk; half_line = hl;
      nf = m_fault || (m_acc > BUD);
      if (nf) nc = 0;
      else if (!m_clamp && v > t_on) nc = 1;
      else if (m_clamp && v < t_off) nc = 0;
      else nc = m_clamp;
      nw = m_win; na = m_acc; nova = m_ova;
      if (tk) begin
         if (m_win == WIN - 1) begin nw = 0; na = 0; end
         else begin nw = m_win + 1; na = m_acc + int'(m_clamp); end
         if (m_ovf) nova = (m_ova < AVMAX) ? m_ova + 1 : m_ova;
         else       nova = (m_ova > 0) ? m_ova - 1 : 0;
      end
      if (m_clamp) nr = HOLD;
      else if (hl && m_rc > 0) nr = m_rc - 1;
      else nr = m_rc;
      no = (v > t_ov);
      nt = m_ovt || (m_ova >= EVT);
      @(posedge clk); #1;
      m_clamp = nc; m_fault = nf; m_win = nw; m_acc = na; m_rc = nr;
      m_ovf = no; m_ova = nova; m_ovt = nt;
   endtask

   task automatic do_reset(input int fs);
      @(negedge clk);
      rst_n = 0; vcode = '0; tick = 0; half_line = 0; fs_code = W'(fs);
      t_on = scale(fs, KON); t_off = scale(fs, KOFF); t_ov = scale(fs, KOV);
      m_clamp = 0; m_fault = 0; m_ovf = 0; m_ovt = 0; m_win = 0; m_acc = 0; m_rc = 0; m_ova = 0;
      repeat (3) @(posedge clk);
      #1;
      chk({clamp_en, cop_fault, clamp_recent, ov_flag, ov_shutdown} == 5'b0, "R1 reset outputs",
          int'({clamp_en, cop_fault, clamp_recent, ov_flag, ov_shutdown}), 0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      chk({clamp_en, cop_fault, clamp_recent, ov_flag, ov_shutdown} == 5'b0, "R1 after release",
          int'({clamp_en, cop_fault, clamp_recent, ov_flag, ov_shutdown}), 0);
   endtask

   // drive the clamp on until n ticks of on-time are counted, then release
   task automatic burst(input int n);
      int cnt = 0;
      do begin
         if (clamp_en) cnt++;
         cyc((cnt >= n) ? t_off - 5 : t_on + 3, 1'b1, 1'b0);
      end while (cnt < n);
   endtask

   task automatic boundaries();
      repeat (3) cyc(t_on, 0, 0);
      chk(clamp_en == 0, "R2 R10 equal to turn-on stays off", int'(clamp_en), 0);
      cyc(t_on + 1, 0, 0);
      chk(clamp_en == 1, "R2 R10 above turn-on", int'(clamp_en), 1);
      repeat (3) cyc(t_off, 0, 0);
      chk(clamp_en == 1, "R3 R10 equal to turn-off holds", int'(clamp_en), 1);
      cyc(t_off - 1, 0, 0);
      chk(clamp_en == 0, "R3 below turn-off", int'(clamp_en), 0);
      chk(clamp_recent == 1, "R7 hold after release", int'(clamp_recent), 1);
      repeat (5) cyc(t_off - 1, 0, 0);
      chk(clamp_recent == 1, "R7 no strobe keeps hold", int'(clamp_recent), 1);
      repeat (HOLD - 1) cyc(t_off - 1, 0, 1);
      chk(clamp_recent == 1, "R7 before last strobe", int'(clamp_recent), 1);
      cyc(t_off - 1, 0, 1);
      chk(clamp_recent == 0, "R7 after last strobe", int'(clamp_recent), 0);
      cyc(t_ov, 0, 0);
      chk(ov_flag == 0, "R8 R10 equal to ov threshold", int'(ov_flag), 0);
      cyc(t_ov + 1, 0, 0);
      chk(ov_flag == 1, "R8 above ov threshold", int'(ov_flag), 1);
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));

      // directed: window budget and clearing
      do_reset(1000);
      burst(BUD);
      repeat (45) cyc(t_off - 5, 1, 0);
      chk(cop_fault == 0, "R5 count equal to budget", int'(cop_fault), 0);
      burst(BUD);
      repeat (10) cyc(t_off - 5, 1, 0);
      chk(cop_fault == 0, "R4 window clears count", int'(cop_fault), 0);
      do_reset(1000);
      burst(BUD + 1);
      repeat (2) cyc(t_off - 5, 1, 0);
      chk(cop_fault == 1, "R5 budget exceeded", int'(cop_fault), 1);
      repeat (4) cyc(t_on + 20, 1, 0);
      chk(clamp_en == 0, "R6 clamp held off by fault", int'(clamp_en), 0);
      repeat (60) cyc(0, 1, 0);
      chk(cop_fault == 1, "R5 fault sticky across windows", int'(cop_fault), 1);

      // directed: overvoltage average
      do_reset(800);
      repeat (EVT) cyc(t_ov + 2, 1, 0);
      chk(ov_shutdown == 0, "R9 not yet at event", int'(ov_shutdown), 0);
      repeat (3) cyc(t_ov + 2, 1, 0);
      chk(ov_shutdown == 1, "R9 event reached", int'(ov_shutdown), 1);
      repeat (40) cyc(0, 1, 0);
      chk(ov_shutdown == 1, "R9 shutdown sticky", int'(ov_shutdown), 1);

      // random segments
      for (int s = 0; s < 8; s++) begin
         int fs;
         fs = 600 + int'($urandom % 400);
         do_reset(fs);
         boundaries();
         for (int i = 0; i < 300; i++) begin
            int v, dwell;
            case ($urandom % 8)
               0: v = int'($urandom % 32'(t_off));
               1: v = t_off;
               2: v = t_on;
               3: v = t_on + 1;
               4: v = t_ov;
               5: v = t_ov + 1 + int'($urandom % 20);
               6: v = t_off + 1 + int'($urandom % 32'(t_on - t_off));
               default: v = t_off - 1;
            endcase
            if (v > 1023) v = 1023;
            dwell = 1 + int'($urandom % 8);
            for (int d = 0; d < dwell; d++)
               cyc(v, ($urandom % 3) == 0, ($urandom % 5) == 0);
         end
      end
      @(negedge clk);
      cmp_model();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule